// File: doc/BRIEF.md
# IPv4 Forwarding Header Screen

This block watches a frame that arrives one byte per clock on a stream with a valid and a last flag. While the bytes go by, it takes in the Ethernet header and a fixed 20-byte IPv4 header. When the last byte arrives, it decides whether a router may forward the packet. One clock after that byte it presents, for a single cycle, a verdict, the destination address and, for a packet that can be forwarded, the TTL and header checksum rewritten for the next hop. Three saturating counters follow the received, rejected and forwarded IPv4 traffic.

The sequencing is done by a three-state machine. ST_ETH covers frame bytes 0 to 13. ST_IP covers bytes 14 to 33, where the header checksum is summed and the destination is captured. ST_BODY covers byte 34 and later. The transitions are as follows. ST_ETH moves to ST_IP when byte 13 is accepted without last. ST_IP moves to ST_BODY when byte 33 is accepted without last. Every state returns to ST_ETH on any byte flagged last, and otherwise keeps its state. Header fields are taken from the frame's byte positions, counted from 0, in network (big-endian) order. Bytes never enter the checksum sum from any other state.

Top module: `ipv4_fwd_screen`

## Requirements
- R1: While reset is held, and right after it, res_valid is 0 and all three counters read 0.
- R2: res_valid is 1 in exactly the cycle after a byte accepted with in_last=1, and 0 in every other cycle.
- R3: A frame of fewer than 34 bytes gets verdict 1 (too short), whatever else it contains. For verdicts 1 and 2, res_dst_addr, res_ttl_new and res_csum_new are 0 and no counter changes.
- R4: A frame of at least 34 bytes whose type field (bytes 12..13) is not 0x0800 gets verdict 2 (not IPv4).
- R5: For verdicts 0 and 3, res_dst_addr equals bytes 30,31,32,33 with byte 30 as the most significant byte. Bytes 0a 02 00 02 give 0x0a020002.
- R6: Byte 14 must be 0x45 (version 4 in the upper nibble, header length 5 words in the lower nibble). Any other value gives verdict 3 (header error).
- R7: The total length field (bytes 16..17) must be at least 20, and the frame length must be at least 14 plus the total length. Extra trailing bytes are allowed. A violation gives verdict 3.
- R8: The ones'-complement sum of the ten 16-bit header words (bytes 14..33) must equal 0xFFFF. Otherwise the verdict is 3.
- R9: A TTL (byte 22) of 0 or 1 gives verdict 3.
- R10: A frame that passes every rule gets verdict 0 (forward). res_ttl_new is the TTL minus 1, and res_csum_new is the received checksum (bytes 24..25) plus 0x0100 in ones'-complement arithmetic, which is equal to a full recomputation.
- R11: cnt_rx counts verdicts 0 and 3, cnt_hdr_err counts verdict 3, and cnt_fwd counts verdict 0. Each counter stops at 2^CNT_W-1.
- R12: Cycles with in_valid=0 are ignored. A frame with idle gaps gives the same result as the same frame without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Marks the final byte of the frame |
| res_valid | output | 1 | Result strobe, one cycle |
| res_verdict | output | 2 | 0 forward, 1 too short, 2 not IPv4, 3 header error |
| res_dst_addr | output | 32 | Destination IPv4 address |
| res_ttl_new | output | 8 | Decremented TTL |
| res_csum_new | output | 16 | Updated header checksum |
| cnt_rx | output | CNT_W | IPv4 packets received |
| cnt_hdr_err | output | CNT_W | Packets with header errors |
| cnt_fwd | output | CNT_W | Packets forwarded |

## Verification
The hardest cases to reach are frames that end exactly on a header boundary. In a 34-byte frame the last byte is also the final destination byte and the final checksum word, so the decision must use values that have not yet been registered. A frame whose length only just covers its total length field raises the same issue. The stimulus table builds these frames byte for byte, computes a correct checksum in the bench, and then breaks one field at a time so that each rule is isolated. A long run of frames that are all forwarded drives a narrowed counter into saturation.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        VERD_FWD     = 2'd0,
        VERD_SHORT   = 2'd1,
        VERD_NOT_IP  = 2'd2,
        VERD_HDR_ERR = 2'd3
    } verdict_e;

    typedef enum logic [1:0] {
        ST_ETH  = 2'd0,
        ST_IP   = 2'd1,
        ST_BODY = 2'd2
    } phase_e;

    localparam int          ETH_BYTES   = 14;
    localparam int          IP_BYTES    = 20;
    localparam int          MIN_FRAME   = ETH_BYTES + IP_BYTES;
    localparam logic [15:0] ETYPE_IPV4  = 16'h0800;
    localparam logic [7:0]  VER_IHL_OK  = 8'h45;
    localparam int          OFS_ETYPE   = 12;
    localparam int          OFS_VERIHL  = ETH_BYTES;
    localparam int          OFS_TOTLEN  = ETH_BYTES + 2;
    localparam int          OFS_TTL     = ETH_BYTES + 8;
    localparam int          OFS_CSUM    = ETH_BYTES + 10;
    localparam int          OFS_DST     = ETH_BYTES + 16;

endpackage

// File: rtl/oc_add16.sv
module oc_add16 (
    input  logic [15:0] a,
    input  logic [15:0] b,
    output logic [15:0] y
);
    logic [16:0] raw;

    always_comb begin
        raw = {1'b0, a} + {1'b0, b};
        y   = raw[15:0] + {15'd0, raw[16]};
    end
endmodule

// File: rtl/sat_counter.sv
module sat_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (inc && q != TOP)
            q <= q + 1'b1;
    end

    assert_sat_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q == TOP) |=> (q == TOP));

    assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q == $past(q)) || (q == $past(q) + 1'b1));
endmodule

// File: rtl/ipv4_fwd_screen.sv
module ipv4_fwd_screen
    import scr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    input  logic             in_last,
    output logic             res_valid,
    output logic [1:0]       res_verdict,
    output logic [31:0]      res_dst_addr,
    output logic [7:0]       res_ttl_new,
    output logic [15:0]      res_csum_new,
    output logic [CNT_W-1:0] cnt_rx,
    output logic [CNT_W-1:0] cnt_hdr_err,
    output logic [CNT_W-1:0] cnt_fwd
);
    localparam int               SUM_W   = ((LEN_W > 16) ? LEN_W : 16) + 1;
    localparam logic [LEN_W-1:0] IDX_TOP = '1;

    phase_e           phase_q, phase_n;
    logic [LEN_W-1:0] idx_q, idx_n;
    logic [15:0]      etype_q, etype_n, etype_c;
    logic [7:0]       verihl_q, verihl_n, verihl_c;
    logic [15:0]      tot_q, tot_n, tot_c;
    logic [7:0]       ttl_q, ttl_n, ttl_c;
    logic [15:0]      ck_q, ck_n, ck_c;
    logic [31:0]      dst_q, dst_n, dst_c;
    logic [7:0]       hi_q, hi_n, hi_c;
    logic [15:0]      acc_q, acc_n, acc_c;
    logic [15:0]      acc_add, ck_fwd;
    logic             fin, start, long_enough, hdr_ok;
    logic [SUM_W-1:0] frame_len, need_len;
    verdict_e         verd;
    logic             inc_rx, inc_err, inc_fwd;

    assign fin   = in_valid && in_last;
    assign start = (idx_q == '0);

    oc_add16 u_sum_add (.a(acc_c), .b({hi_c, in_data}), .y(acc_add));
    oc_add16 u_fwd_add (.a(ck_n),  .b(16'h0100),        .y(ck_fwd));

    // Phase sequencing
    always_comb begin
        phase_n = phase_q;
        if (in_valid) begin
            unique case (phase_q)
                ST_ETH:  if (in_last) phase_n = ST_ETH;
                         else if (idx_q == LEN_W'(ETH_BYTES - 1)) phase_n = ST_IP;
                ST_IP:   if (in_last) phase_n = ST_ETH;
                         else if (idx_q == LEN_W'(MIN_FRAME - 1)) phase_n = ST_BODY;
                ST_BODY: if (in_last) phase_n = ST_ETH;
                default: phase_n = ST_ETH;
            endcase
        end
    end

    // Field capture, fields cleared on the first byte of a frame
    always_comb begin
        etype_c  = start ? '0 : etype_q;
        verihl_c = start ? '0 : verihl_q;
        tot_c    = start ? '0 : tot_q;
        ttl_c    = start ? '0 : ttl_q;
        ck_c     = start ? '0 : ck_q;
        dst_c    = start ? '0 : dst_q;
        hi_c     = start ? '0 : hi_q;
        acc_c    = start ? '0 : acc_q;
        etype_n  = etype_c;
        verihl_n = verihl_c;
        tot_n    = tot_c;
        ttl_n    = ttl_c;
        ck_n     = ck_c;
        dst_n    = dst_c;
        hi_n     = hi_c;
        acc_n    = acc_c;
        idx_n    = idx_q;
        if (in_valid) begin
            idx_n = in_last ? '0 : ((idx_q == IDX_TOP) ? idx_q : idx_q + 1'b1);
            if (idx_q == LEN_W'(OFS_ETYPE))      etype_n[15:8] = in_data;
            if (idx_q == LEN_W'(OFS_ETYPE + 1))  etype_n[7:0]  = in_data;
            if (idx_q == LEN_W'(OFS_VERIHL))     verihl_n      = in_data;
            if (idx_q == LEN_W'(OFS_TOTLEN))     tot_n[15:8]   = in_data;
            if (idx_q == LEN_W'(OFS_TOTLEN + 1)) tot_n[7:0]    = in_data;
            if (idx_q == LEN_W'(OFS_TTL))        ttl_n         = in_data;
            if (idx_q == LEN_W'(OFS_CSUM))       ck_n[15:8]    = in_data;
            if (idx_q == LEN_W'(OFS_CSUM + 1))   ck_n[7:0]     = in_data;
            if (phase_q == ST_IP) begin
                if (idx_q >= LEN_W'(OFS_DST)) dst_n = {dst_c[23:0], in_data};
                if (idx_q[0]) acc_n = acc_add;
                else          hi_n  = in_data;
            end
        end
    end

    // Decision on the last byte, using the values that include it
    always_comb begin
        long_enough = (phase_q == ST_BODY) ||
                      (phase_q == ST_IP && idx_q == LEN_W'(MIN_FRAME - 1));
        frame_len   = SUM_W'(idx_q) + SUM_W'(1);
        need_len    = SUM_W'(ETH_BYTES) + SUM_W'(tot_n);
        hdr_ok      = (verihl_n == VER_IHL_OK) &&
                      (tot_n >= 16'(IP_BYTES)) &&
                      (frame_len >= need_len) &&
                      (acc_n == 16'hFFFF) &&
                      (ttl_n > 8'd1);
        if (!long_enough)               verd = VERD_SHORT;
        else if (etype_n != ETYPE_IPV4) verd = VERD_NOT_IP;
        else if (!hdr_ok)               verd = VERD_HDR_ERR;
        else                            verd = VERD_FWD;
        inc_fwd = fin && (verd == VERD_FWD);
        inc_err = fin && (verd == VERD_HDR_ERR);
        inc_rx  = inc_fwd || inc_err;
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= ST_ETH;
            idx_q    <= '0;
            etype_q  <= '0;
            verihl_q <= '0;
            tot_q    <= '0;
            ttl_q    <= '0;
            ck_q     <= '0;
            dst_q    <= '0;
            hi_q     <= '0;
            acc_q    <= '0;
        end else begin
            phase_q  <= phase_n;
            idx_q    <= idx_n;
            etype_q  <= etype_n;
            verihl_q <= verihl_n;
            tot_q    <= tot_n;
            ttl_q    <= ttl_n;
            ck_q     <= ck_n;
            dst_q    <= dst_n;
            hi_q     <= hi_n;
            acc_q    <= acc_n;
        end
    end

    // Output process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_verdict  <= VERD_FWD;
            res_dst_addr <= '0;
            res_ttl_new  <= '0;
            res_csum_new <= '0;
        end else begin
            res_valid <= fin;
            if (fin) begin
                res_verdict  <= verd;
                res_dst_addr <= (verd == VERD_FWD || verd == VERD_HDR_ERR) ? dst_n : '0;
                res_ttl_new  <= (verd == VERD_FWD) ? ttl_n - 8'd1 : '0;
                res_csum_new <= (verd == VERD_FWD) ? ck_fwd : '0;
            end
        end
    end

    sat_counter #(.W(CNT_W)) u_cnt_rx  (.clk(clk), .rst_n(rst_n), .inc(inc_rx),  .q(cnt_rx));
    sat_counter #(.W(CNT_W)) u_cnt_err (.clk(clk), .rst_n(rst_n), .inc(inc_err), .q(cnt_hdr_err));
    sat_counter #(.W(CNT_W)) u_cnt_fwd (.clk(clk), .rst_n(rst_n), .inc(inc_fwd), .q(cnt_fwd));

    assert_res_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_last) |=> res_valid);

    assert_res_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_last) |=> !res_valid);

    assert_quiet_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_verdict == VERD_SHORT || res_verdict == VERD_NOT_IP)) |->
        (res_dst_addr == '0 && res_ttl_new == '0 && res_csum_new == '0));

    assert_body_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == ST_BODY) |-> (idx_q >= LEN_W'(MIN_FRAME)));

    assert_fwd_ttl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_verdict == VERD_FWD) |-> (res_ttl_new != 8'd0));

    assert_cnt_order_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_rx >= cnt_fwd) && (cnt_rx >= cnt_hdr_err));

    assert_cnt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(cnt_rx) && $stable(cnt_fwd) && $stable(cnt_hdr_err)));
endmodule

// File: tb/test_ipv4_fwd_screen.sv
module test_ipv4_fwd_screen;
    import scr_pkg::*;

    localparam int CNT_W = 4;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_last;
    logic [7:0]  in_data;
    logic        res_valid;
    logic [1:0]  res_verdict;
    logic [31:0] res_dst_addr;
    logic [7:0]  res_ttl_new;
    logic [15:0] res_csum_new;
    logic [CNT_W-1:0] cnt_rx, cnt_hdr_err, cnt_fwd;

    always #10 clk = ~clk;

    ipv4_fwd_screen #(.CNT_W(CNT_W), .LEN_W(16)) i_ipv4_fwd_screen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .res_valid(res_valid), .res_verdict(res_verdict),
        .res_dst_addr(res_dst_addr), .res_ttl_new(res_ttl_new),
        .res_csum_new(res_csum_new), .cnt_rx(cnt_rx),
        .cnt_hdr_err(cnt_hdr_err), .cnt_fwd(cnt_fwd)
    );

    typedef struct packed {
        logic [7:0]  len;
        logic [15:0] etype;
        logic [7:0]  verihl;
        logic [15:0] tot;
        logic [7:0]  ttl;
        logic        bad_ck;
        logic [31:0] dst;
        logic [1:0]  verd;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VTAB [NV] = '{
        '{8'd60, 16'h0800, 8'h45, 16'd46, 8'd64,  1'b0, 32'h0a020002, 2'd0}, // R10 R5 basic forward
        '{8'd34, 16'h0800, 8'h45, 16'd20, 8'd2,   1'b0, 32'hc0a80101, 2'd0}, // R10 minimum frame, TTL 2
        '{8'd33, 16'h0800, 8'h45, 16'd19, 8'd64,  1'b0, 32'h0a000001, 2'd1}, // R3 one byte short
        '{8'd10, 16'h0800, 8'h45, 16'd20, 8'd64,  1'b0, 32'h0a000001, 2'd1}, // R3 very short
        '{8'd60, 16'h86dd, 8'h45, 16'd46, 8'd64,  1'b0, 32'h0a000002, 2'd2}, // R4 other type
        '{8'd60, 16'h0800, 8'h65, 16'd46, 8'd64,  1'b0, 32'h0a000003, 2'd3}, // R6 version 6
        '{8'd60, 16'h0800, 8'h46, 16'd46, 8'd64,  1'b0, 32'h0a000004, 2'd3}, // R6 header length 6
        '{8'd60, 16'h0800, 8'h45, 16'd50, 8'd64,  1'b0, 32'h0a000005, 2'd3}, // R7 total exceeds frame
        '{8'd60, 16'h0800, 8'h45, 16'd19, 8'd64,  1'b0, 32'h0a000006, 2'd3}, // R7 total below 20
        '{8'd60, 16'h0800, 8'h45, 16'd46, 8'd64,  1'b1, 32'h0a000007, 2'd3}, // R8 bad checksum
        '{8'd60, 16'h0800, 8'h45, 16'd46, 8'd1,   1'b0, 32'h0a000008, 2'd3}, // R9 TTL 1
        '{8'd60, 16'h0800, 8'h45, 16'd46, 8'd0,   1'b0, 32'h0a000009, 2'd3}, // R9 TTL 0
        '{8'd64, 16'h0800, 8'h45, 16'd50, 8'd255, 1'b0, 32'hac10fe01, 2'd0}, // R7 exact length fit
        '{8'd20, 16'h1234, 8'h00, 16'd0,  8'd0,   1'b0, 32'h00000000, 2'd1}  // R3 short wins over type
    };

    logic [7:0] fb [0:79];
    int n_chk = 0;
    int n_bad = 0;
    int exp_rx = 0, exp_err = 0, exp_fwd = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] hdr_csum(input logic [7:0] ttl_v);
        logic [31:0] s = 0;
        for (int k = 0; k < 10; k++) begin
            logic [7:0] h, l;
            h = fb[14 + 2*k];
            l = fb[15 + 2*k];
            if (k == 4) h = ttl_v;
            if (k == 5) begin h = 8'h00; l = 8'h00; end
            s = s + {16'd0, h, l};
        end
        s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        s = {16'd0, s[15:0]} + {16'd0, s[31:16]};
        return ~s[15:0];
    endfunction

    task automatic build(input vec_t v);
        logic [15:0] c;
        for (int k = 0; k < 80; k++) fb[k] = 8'(k * 7 + 3);
        fb[12] = v.etype[15:8]; fb[13] = v.etype[7:0];
        fb[14] = v.verihl;      fb[15] = 8'h00;
        fb[16] = v.tot[15:8];   fb[17] = v.tot[7:0];
        fb[18] = 8'h17; fb[19] = 8'hd4; fb[20] = 8'h00; fb[21] = 8'h00;
        fb[22] = v.ttl;         fb[23] = 8'h01;
        fb[26] = 8'h0a; fb[27] = 8'h01; fb[28] = 8'h00; fb[29] = 8'h02;
        fb[30] = v.dst[31:24];  fb[31] = v.dst[23:16];
        fb[32] = v.dst[15:8];   fb[33] = v.dst[7:0];
        c = hdr_csum(v.ttl);
        if (v.bad_ck) c = c ^ 16'h0001;
        fb[24] = c[15:8];       fb[25] = c[7:0];
    endtask

    task automatic send(input int len, input bit gaps);
        for (int k = 0; k < len; k++) begin
            if (gaps && (k % 5 == 2)) begin
                @(negedge clk);
                in_valid = 1'b0; in_last = 1'b0; in_data = 8'hee;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = fb[k];
            in_last  = (k == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
    endtask

    function automatic int sat(input int x);
        return (x > CMAX) ? CMAX : x;
    endfunction

    // Sends one vector, checks the result cycle and the cycle after it.
    task automatic run_vec(input vec_t v, input bit gaps, input string req);
        logic [7:0]  e_ttl;
        logic [15:0] e_ck;
        logic [31:0] e_dst;
        build(v);
        e_ttl = (v.verd == 2'd0) ? v.ttl - 8'd1 : 8'd0;
        e_ck  = (v.verd == 2'd0) ? hdr_csum(v.ttl - 8'd1) : 16'd0;
        e_dst = (v.verd == 2'd0 || v.verd == 2'd3) ? v.dst : 32'd0;
        if (v.verd == 2'd0) begin exp_rx = sat(exp_rx + 1); exp_fwd = sat(exp_fwd + 1); end
        if (v.verd == 2'd3) begin exp_rx = sat(exp_rx + 1); exp_err = sat(exp_err + 1); end
        send(int'(v.len), gaps);
        chk(res_valid == 1'b1, "R2", "res_valid after last", 32'(res_valid), 32'd1);
        chk(res_verdict == v.verd, req, "verdict", 32'(res_verdict), 32'(v.verd));
        chk(res_dst_addr == e_dst, "R5", "dst", res_dst_addr, e_dst);
        chk(res_ttl_new == e_ttl, "R10", "ttl_new", 32'(res_ttl_new), 32'(e_ttl));
        chk(res_csum_new == e_ck, "R10", "csum_new", 32'(res_csum_new), 32'(e_ck));
        chk(cnt_rx == CNT_W'(exp_rx), "R11", "cnt_rx", 32'(cnt_rx), 32'(exp_rx));
        chk(cnt_hdr_err == CNT_W'(exp_err), "R11", "cnt_hdr_err", 32'(cnt_hdr_err), 32'(exp_err));
        chk(cnt_fwd == CNT_W'(exp_fwd), "R11", "cnt_fwd", 32'(cnt_fwd), 32'(exp_fwd));
        @(negedge clk);
        chk(res_valid == 1'b0, "R2", "res_valid second cycle", 32'(res_valid), 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(res_valid == 1'b0, "R1", "res_valid in reset", 32'(res_valid), 32'd0);
        chk(cnt_rx == '0 && cnt_hdr_err == '0 && cnt_fwd == '0, "R1", "counters in reset",
            32'(cnt_rx), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid == 1'b0, "R1", "res_valid after reset", 32'(res_valid), 32'd0);

        foreach (VTAB[i]) begin
            string r;
            unique case (i)
                2, 3, 13: r = "R3";
                4:        r = "R4";
                5, 6:     r = "R6";
                7, 8, 12: r = "R7";
                9:        r = "R8";
                10, 11:   r = "R9";
                default:  r = "R10";
            endcase
            run_vec(VTAB[i], 1'b0, r);
        end

        // R12 idle gaps inside a forwarded frame and a rejected one
        run_vec(VTAB[0], 1'b1, "R12");
        run_vec(VTAB[9], 1'b1, "R12");

        // R11 saturation of the narrowed counters
        for (int k = 0; k < 10; k++) run_vec(VTAB[1], 1'b0, "R11");
        chk(cnt_rx == CNT_W'(CMAX), "R11", "cnt_rx saturated", 32'(cnt_rx), 32'(CMAX));
        run_vec(VTAB[11], 1'b0, "R11");

        // R1 reset clears counters after activity
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(cnt_rx == '0 && cnt_fwd == '0 && cnt_hdr_err == '0, "R1", "counters after reset",
            32'(cnt_rx), 32'd0);
        rst_n = 1'b1;
        exp_rx = 0; exp_err = 0; exp_fwd = 0;
        run_vec(VTAB[12], 1'b0, "R10");

        finish_run();
    end
endmodule